// File: doc/BRIEF.md
# Synthesizer Serial Divide-Ratio Loader

This block sits between a three-wire serial host link (data, bit clock, strobe) and the divide-ratio registers of a pulse-swallow frequency synthesizer. The host shifts a word in most significant bit first, one bit per rising edge of the bit clock. It then raises the strobe. The block samples all three lines into its own system clock domain and counts the bits of the word. The last bit shifted, which sits in the word's least significant position, is a control bit. It chooses which of two differently formatted registers the word is meant for.

A reference word carries the reference divide ratio and the prescaler-select bit. A counter word carries the swallow count and the programmable count. A word is accepted only if its length matches the length its control bit implies and its ratio is legal. When a word is accepted, the block updates the addressed register and emits a one-cycle update pulse. A word of the wrong length raises a one-cycle framing error. A word with an illegal ratio is dropped without any change at the outputs.

Top module: `divratio_loader`

## Requirements
- R1: While reset is asserted and just after it is released, ref_ratio_o, presc_sel_o, prog_n_o, swallow_a_o, upd_o and frame_err_o are all zero.
- R2: A 16-bit word whose bit 0 is 1 is a reference word. On the strobe it loads bits 14..1 into ref_ratio_o and bit 15 into presc_sel_o. Bits travel MSB first, so bit 0 is the last one shifted. presc_sel_o = 0 selects the 128/129 prescaler and 1 selects 64/65.
- R3: A 19-bit word whose bit 0 is 0 is a counter word. On the strobe it loads bits 7..1 into swallow_a_o and bits 18..8 into prog_n_o.
- R4: An accepted reference word leaves prog_n_o and swallow_a_o unchanged. An accepted counter word leaves ref_ratio_o and presc_sel_o unchanged.
- R5: If the number of bits shifted since the previous strobe differs from the length that the control bit implies, frame_err_o is high for one cycle. In that case upd_o stays low and no output register changes. A strobe with zero bits shifted is also an error.
- R6: A reference ratio below 8 is rejected: no update pulse, no error and no change at the outputs. Ratios 8 and 16383 are accepted.
- R7: A programmable count below 3 is rejected in the same way. Counts 3 and 2047 are accepted, and any swallow count from 0 to 127 is accepted.
- R8: The serial lines pass through a two-stage synchronizer. The new register values and a one-cycle upd_o appear on the third system-clock edge after the strobe rises, and not before.
- R9: If a rising bit clock and a rising strobe are seen in the same cycle, the strobe judges the word shifted before that bit. The coincident bit becomes the first bit of the next word.
- R10: Every strobe restarts the bit count, so the next word is counted from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the host; data is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_strobe_i | input | 1 | Strobe; a rising edge commits the shifted word |
| ref_ratio_o | output | 14 | Latched reference divide ratio |
| presc_sel_o | output | 1 | Prescaler select (0: 128/129, 1: 64/65) |
| prog_n_o | output | 11 | Latched programmable count |
| swallow_a_o | output | 7 | Latched swallow count |
| upd_o | output | 1 | One-cycle pulse when a register was updated |
| frame_err_o | output | 1 | One-cycle pulse when a word had the wrong length |

## Verification
Bit capture and word commit can fall in the same system cycle. This happens when the host raises the bit clock and the strobe together. The bench provokes it by driving both lines high on the same edge, directly after a complete reference word. It then checks that the reference word is still accepted with its own value. It also checks that the following counter word is accepted after only 18 further bits, which shows that the coincident bit was counted as that word's first bit and that the strobe restarted the count.

// File: rtl/divld_pkg.sv
package divld_pkg;
  // Field widths of the two word formats
  localparam int REF_BITS  = 14;
  localparam int SWAL_BITS = 7;
  localparam int PROG_BITS = 11;
  // Smallest legal ratios
  localparam int REF_FLOOR  = 8;
  localparam int PROG_FLOOR = 3;
  localparam int SYNC_DEPTH = 2;

  // Meaning of the control bit found in bit 0 of a word
  typedef enum logic {
    WK_COUNTS = 1'b0,
    WK_REF    = 1'b1
  } word_kind_e;
endpackage

// File: rtl/divld_sync.sv
module divld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/divld_shifter.sv
module divld_shifter #(
  parameter int SH_W  = 19,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             bit_val,
  input  logic             load_evt,
  output logic [SH_W-1:0]  shreg_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (bit_evt) begin
      shreg <= {shreg[SH_W-2:0], bit_val};
    end
  end

  // Saturating bit count; a strobe restarts it (a coincident bit counts as one)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_evt) begin
      cnt <= bit_evt ? CNT_W'(1) : '0;
    end else if (bit_evt && cnt != CNT_MAX) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign shreg_o = shreg;
  assign cnt_o   = cnt;

  // R10: a strobe without a bit leaves an empty count
  assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !bit_evt) |=> (cnt == '0));

  // R9: a bit coinciding with the strobe opens the next word
  assert_coincident_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && bit_evt) |=> (cnt == CNT_W'(1) && shreg[0] == $past(bit_val)));
endmodule

// File: rtl/divld_decode.sv
module divld_decode
  import divld_pkg::*;
#(
  parameter int REF_W  = REF_BITS,
  parameter int A_W    = SWAL_BITS,
  parameter int N_W    = PROG_BITS,
  parameter int R_MIN  = REF_FLOOR,
  parameter int N_MIN  = PROG_FLOOR,
  parameter int SH_W   = 19,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [SH_W-1:0]  shreg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [REF_W-1:0] ref_o,
  output logic             presc_o,
  output logic [N_W-1:0]   n_o,
  output logic [A_W-1:0]   a_o,
  output logic             upd_o,
  output logic             err_o
);
  localparam int REF_LEN = REF_W + 2;
  localparam int NA_LEN  = 1 + A_W + N_W;

  // Length implied by the control bit
  function automatic logic [CNT_W-1:0] need_len(input word_kind_e k);
    return (k == WK_REF) ? CNT_W'(REF_LEN) : CNT_W'(NA_LEN);
  endfunction

  function automatic logic ref_legal(input logic [REF_W-1:0] r);
    return r >= REF_W'(R_MIN);
  endfunction

  function automatic logic prog_legal(input logic [N_W-1:0] n);
    return n >= N_W'(N_MIN);
  endfunction

  word_kind_e       kind;
  logic             len_ok;
  logic [REF_W-1:0] ref_fld;
  logic             presc_fld;
  logic [A_W-1:0]   a_fld;
  logic [N_W-1:0]   n_fld;
  logic             accept_ref;
  logic             accept_cnt;
  logic             frame_bad;

  always_comb begin
    kind       = word_kind_e'(shreg_i[0]);
    len_ok     = (cnt_i == need_len(kind));
    ref_fld    = shreg_i[REF_W:1];
    presc_fld  = shreg_i[REF_W+1];
    a_fld      = shreg_i[A_W:1];
    n_fld      = shreg_i[A_W+N_W:A_W+1];
    frame_bad  = load_evt && !len_ok;
    accept_ref = load_evt && len_ok && kind == WK_REF    && ref_legal(ref_fld);
    accept_cnt = load_evt && len_ok && kind == WK_COUNTS && prog_legal(n_fld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o   <= '0;
      presc_o <= 1'b0;
      n_o     <= '0;
      a_o     <= '0;
      upd_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      upd_o <= accept_ref || accept_cnt;
      err_o <= frame_bad;
      if (accept_ref) begin
        ref_o   <= ref_fld;
        presc_o <= presc_fld;
      end
      if (accept_cnt) begin
        n_o <= n_fld;
        a_o <= a_fld;
      end
    end
  end

  // R5: a framing error leaves every register as it was
  assert_err_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(ref_o) && $stable(presc_o) && $stable(n_o) && $stable(a_o) && !upd_o));

  // R6: a changed reference ratio is never below the floor
  assert_ref_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_o != $past(ref_o)) |-> (ref_o >= REF_W'(R_MIN)));

  // R7: a changed programmable count is never below the floor
  assert_prog_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_o != $past(n_o)) |-> (n_o >= N_W'(N_MIN)));

  // R4: only one of the two registers moves per update
  assert_one_register_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ref_o) || $changed(presc_o)) |-> ($stable(n_o) && $stable(a_o)));

  // R8: without a strobe the next cycle shows no update and no change
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (!upd_o && !err_o && $stable(ref_o) && $stable(n_o)));

  // R8: the update pulse lasts exactly one cycle
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);
endmodule

// File: rtl/divratio_loader.sv
module divratio_loader
  import divld_pkg::*;
#(
  parameter int REF_W  = REF_BITS,
  parameter int A_W    = SWAL_BITS,
  parameter int N_W    = PROG_BITS,
  parameter int R_MIN  = REF_FLOOR,
  parameter int N_MIN  = PROG_FLOOR,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             ser_strobe_i,
  output logic [REF_W-1:0] ref_ratio_o,
  output logic             presc_sel_o,
  output logic [N_W-1:0]   prog_n_o,
  output logic [A_W-1:0]   swallow_a_o,
  output logic             upd_o,
  output logic             frame_err_o
);
  localparam int REF_LEN = REF_W + 2;
  localparam int NA_LEN  = 1 + A_W + N_W;
  localparam int SH_W    = (REF_LEN > NA_LEN) ? REF_LEN : NA_LEN;
  localparam int CNT_W   = $clog2(SH_W + 1) + 1;

  logic [2:0] sync_q;
  logic       clk_s, dat_s, stb_s;
  logic       clk_d, stb_d;
  logic       bit_evt, load_evt;

  divld_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_strobe_i, ser_data_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  assign {stb_s, dat_s, clk_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      stb_d <= 1'b0;
    end else begin
      clk_d <= clk_s;
      stb_d <= stb_s;
    end
  end

  // Named internal events
  assign bit_evt  = clk_s & ~clk_d;
  assign load_evt = stb_s & ~stb_d;

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;

  divld_shifter #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_evt  (bit_evt),
    .bit_val  (dat_s),
    .load_evt (load_evt),
    .shreg_o  (shreg),
    .cnt_o    (cnt)
  );

  divld_decode #(
    .REF_W (REF_W), .A_W (A_W), .N_W (N_W),
    .R_MIN (R_MIN), .N_MIN (N_MIN),
    .SH_W  (SH_W),  .CNT_W (CNT_W)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .shreg_i  (shreg),
    .cnt_i    (cnt),
    .ref_o    (ref_ratio_o),
    .presc_o  (presc_sel_o),
    .n_o      (prog_n_o),
    .a_o      (swallow_a_o),
    .upd_o    (upd_o),
    .err_o    (frame_err_o)
  );

  // R8: edge events are single-cycle
  assert_strobe_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);
endmodule

// File: tb/sim_divratio_loader.sv
module sim_divratio_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
  logic [13:0] ref_ratio;
  logic        presc_sel;
  logic [10:0] prog_n;
  logic [6:0]  swallow_a;
  logic        upd, ferr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  divratio_loader u0 (
    .clk (clk), .rst_n (rst_n),
    .ser_clk_i (ser_clk), .ser_data_i (ser_data), .ser_strobe_i (ser_strobe),
    .ref_ratio_o (ref_ratio), .presc_sel_o (presc_sel),
    .prog_n_o (prog_n), .swallow_a_o (swallow_a),
    .upd_o (upd), .frame_err_o (ferr)
  );

  // Word builders: reference word {presc, ratio, 1}, counter word {N, A, 0}
  function automatic logic [18:0] mkr(input logic p, input logic [13:0] r);
    return {3'b000, p, r, 1'b1};
  endfunction
  function automatic logic [18:0] mkc(input logic [10:0] n, input logic [6:0] a);
    return {n, a, 1'b0};
  endfunction

  // Each entry: {bit count, word}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {5'd16, mkr(1'b1, 14'd100)},
    {5'd19, mkc(11'd500, 7'd37)},
    {5'd16, mkr(1'b0, 14'd8)},
    {5'd16, mkr(1'b1, 14'd7)},
    {5'd19, mkc(11'd3, 7'd127)},
    {5'd19, mkc(11'd2, 7'd5)},
    {5'd16, mkr(1'b1, 14'd16383)},
    {5'd19, mkc(11'd2047, 7'd0)},
    {5'd19, mkr(1'b0, 14'd900)},
    {5'd16, mkc(11'd40, 7'd1)},
    {5'd15, mkr(1'b0, 14'd50)}
  };

  logic [13:0] e_ref = '0;
  logic        e_p   = 1'b0;
  logic [10:0] e_n   = '0;
  logic [6:0]  e_a   = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, "ref_ratio", int'(ref_ratio), int'(e_ref));
    chk(tag, "presc_sel", int'(presc_sel), int'(e_p));
    chk(tag, "prog_n",    int'(prog_n),    int'(e_n));
    chk(tag, "swallow_a", int'(swallow_a), int'(e_a));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [18:0] w, input int len);
    for (int b = len - 1; b >= 0; b--) send_bit(w[b]);
  endtask

  // Strobe, then sample in the cycle after the third clock edge
  task automatic do_load();
    @(negedge clk) ser_strobe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic end_load();
    ser_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "upd in reset", int'(upd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_regs("R1");
    chk("R1", "upd", int'(upd), 0);
    chk("R1", "frame_err", int'(ferr), 0);

    // Table of words
    for (int i = 0; i < NV; i++) begin
      logic [18:0] w;
      int len;
      logic kind;
      int need;
      logic e_upd, e_err;
      string tag;
      w    = VEC[i][18:0];
      len  = int'(VEC[i][23:19]);
      kind = w[0];
      need = kind ? 16 : 19;
      e_upd = 1'b0;
      e_err = 1'b0;
      if (len != need) begin
        e_err = 1'b1;
        tag   = "R5";
      end else if (kind) begin
        if (w[14:1] >= 14'd8) begin
          e_upd = 1'b1; e_ref = w[14:1]; e_p = w[15]; tag = "R2";
        end else tag = "R6";
      end else begin
        if (w[18:8] >= 11'd3) begin
          e_upd = 1'b1; e_n = w[18:8]; e_a = w[7:1]; tag = "R3";
        end else tag = "R7";
      end
      if (w[14:1] == 14'd8 || w[14:1] == 14'd16383) tag = kind ? "R6" : tag;
      if (!kind && (w[18:8] == 11'd3 || w[18:8] == 11'd2047)) tag = (len == need) ? "R7" : tag;
      send_word(w, len);
      do_load();
      chk(tag, "upd", int'(upd), int'(e_upd));
      chk(tag, "frame_err", int'(ferr), int'(e_err));
      chk_regs(e_upd ? "R4" : tag);
      end_load();
    end

    // R8: nothing visible after two edges, update after the third, gone after
    send_word(mkr(1'b0, 14'd1234), 16);
    @(negedge clk) ser_strobe = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8", "upd early", int'(upd), 0);
    chk("R8", "ref early", int'(ref_ratio), int'(e_ref));
    @(negedge clk);
    e_ref = 14'd1234; e_p = 1'b0;
    chk("R8", "upd on time", int'(upd), 1);
    chk("R8", "ref on time", int'(ref_ratio), 1234);
    @(negedge clk);
    chk("R8", "upd one cycle", int'(upd), 0);
    end_load();

    // R5 / R10: strobe with no bits shifted
    do_load();
    chk("R10", "frame_err empty", int'(ferr), 1);
    chk("R10", "upd empty", int'(upd), 0);
    chk_regs("R5");
    end_load();

    // R9: bit clock and strobe rise together
    send_word(mkr(1'b1, 14'd321), 16);
    begin
      logic [18:0] nw;
      nw = mkc(11'd77, 7'd9);
      @(negedge clk) ser_data = nw[18];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      ser_strobe = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      e_ref = 14'd321; e_p = 1'b1;
      chk("R9", "upd coincident", int'(upd), 1);
      chk("R9", "frame_err coincident", int'(ferr), 0);
      chk_regs("R9");
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
      ser_strobe = 1'b0;
      repeat (3) @(negedge clk);
      send_word(nw, 18);
      do_load();
      e_n = 11'd77; e_a = 7'd9;
      chk("R9", "upd next word", int'(upd), 1);
      chk("R10", "frame_err next word", int'(ferr), 0);
      chk_regs("R9");
      end_load();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule